// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Interrupt Routing

This block collects a bank of level-sensitive interrupt sources into 32-bit words and drives two processor request lines. The normal request goes high when any source is active and not masked. The fast request goes high when such a source also has its fast-route bit set. Each source has its own mask bit and its own fast-route bit.

A read-only vector register gives the byte offset of the lowest-numbered source that is active and unmasked. The offset is four times that source's number. The block computes the vector in hardware and applies no priority levels. Software cannot write the vector.

A simple register bus gives access to the following registers:
- a base-address register,
- the per-word mask, fast-route and pending registers,
- the vector register.

The pending words track the source levels. The request lines and the vector are registered, so they react one clock after a source level changes or a register is written.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Each pending word at offset 0x20 + 4*i holds source levels i*32+31..i*32, captured one clock after the source changes; bus writes to the pending words change nothing.
- R2: `irq_o` is high one clock after any source is active whose mask bit (word at 0x30 + 4*i, 1 = blocked) is clear, and low otherwise.
- R3: `fiq_o` is high one clock after any source is active, unmasked and has its fast-route bit set (word at 0x40 + 4*i, 1 = fast); it is never high while `irq_o` is low.
- R4: The vector register at offset 0x00 reads the source number times four, so its bits [1:0] are always 0.
- R5: When several unmasked sources are active, the vector names the lowest-numbered one: words are searched from index 0 upward, and within a word the least significant set bit wins.
- R6: The vector reads 0 when no unmasked source is active.
- R7: Bus writes to the vector offset leave the vector unchanged.
- R8: A write to the base-address register at offset 0x10 stores the data with bits [1:0] forced to 0, and reads return the stored value.
- R9: The word index of the pending, mask and fast-route groups comes from address bits [3:2]. A word index at or beyond the number of words reads 0 and ignores writes. Offsets outside the five blocks read 0.
- R10: After reset, mask, fast-route and base registers are 0, and both request lines and the vector are 0.
- R11: A mask or fast-route write and a source change that arrive in the same clock are both reflected in the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_WORDS*32 | Level interrupt sources, bit n is source n |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can act in the same clock: a register write that changes mask or fast-route bits, and a change on the source levels. Either one alone moves the request lines and the vector. The bench drives a mask write and a new source pattern on the same falling edge. One clock later it compares the vector and both request lines against a reference scan that applies both changes together. A design that took the old mask or the old source levels for that one cycle would fail this comparison.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [3:0] {
    BLK_VEC  = 4'h0,
    BLK_BASE = 4'h1,
    BLK_PEND = 4'h2,
    BLK_MASK = 4'h3,
    BLK_SEL  = 4'h4
  } blk_e;

  // byte offset of a source number: number times four
  function automatic logic [31:0] vec_of_index(input logic [29:0] idx);
    return {idx, 2'b00};
  endfunction

  function automatic logic [31:0] align_word(input logic [31:0] d);
    return d & ~32'h3;
  endfunction

endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wen,
  input  logic [7:0]                    addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_WORDS*DATA_W-1:0]   mask_q,
  output logic [NUM_WORDS*DATA_W-1:0]   sel_q,
  output logic [NUM_WORDS*DATA_W-1:0]   mask_nx,
  output logic [NUM_WORDS*DATA_W-1:0]   sel_nx,
  output logic [31:0]                   base_q
);
  logic [3:0] blk;
  logic [1:0] widx;
  assign blk  = addr[7:4];
  assign widx = addr[3:2];

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    localparam logic [1:0] MY_IDX = 2'(gi);
    logic hit_mask, hit_sel;
    assign hit_mask = wen && (blk == BLK_MASK) && (widx == MY_IDX);
    assign hit_sel  = wen && (blk == BLK_SEL)  && (widx == MY_IDX);

    always_comb begin
      mask_nx[gi*DATA_W +: DATA_W] = hit_mask ? wdata : mask_q[gi*DATA_W +: DATA_W];
      sel_nx[gi*DATA_W +: DATA_W]  = hit_sel  ? wdata : sel_q[gi*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[gi*DATA_W +: DATA_W] <= '0;
        sel_q[gi*DATA_W +: DATA_W]  <= '0;
      end else begin
        mask_q[gi*DATA_W +: DATA_W] <= mask_nx[gi*DATA_W +: DATA_W];
        sel_q[gi*DATA_W +: DATA_W]  <= sel_nx[gi*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      base_q <= '0;
    else if (wen && (blk == BLK_BASE))
      base_q <= align_word(32'(wdata));
  end
endmodule

// File: rtl/vic_scan.sv
module vic_scan
  import vic_pkg::*;
#(
  parameter int NSRC = 96
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] sel,
  output logic            any_irq,
  output logic            any_fiq,
  output logic [31:0]     vec
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] active;
  logic [IDX_W-1:0] first_idx;

  // lowest set bit: descending walk, last hit stays
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  always_comb begin
    active    = pend & ~mask;
    any_irq   = |active;
    any_fiq   = |(active & sel);
    first_idx = lowest_set(active);
    vec       = any_irq ? vec_of_index(30'(first_idx)) : 32'h0;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WORDS*32-1:0]  src_i,
  input  logic [7:0]               bus_addr,
  input  logic                     bus_wen,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     irq_o,
  output logic                     fiq_o
);
  localparam int NSRC = NUM_WORDS * 32;

  logic [NSRC-1:0] pend_q, mask_q, sel_q, mask_nx, sel_nx;
  logic [31:0]     base_q, vec_q, vec_nx;
  logic            irq_nx, fiq_nx;

  vic_regfile #(.NUM_WORDS(NUM_WORDS), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .sel_q(sel_q), .mask_nx(mask_nx), .sel_nx(sel_nx), .base_q(base_q)
  );

  // scan the post-write state so outputs move with the registers
  vic_scan #(.NSRC(NSRC)) u_scan (
    .pend(src_i), .mask(mask_nx), .sel(sel_nx),
    .any_irq(irq_nx), .any_fiq(fiq_nx), .vec(vec_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= src_i;
      irq_o  <= irq_nx;
      fiq_o  <= fiq_nx;
      vec_q  <= vec_nx;
    end
  end

  logic [3:0] rd_blk;
  logic [1:0] rd_idx;
  assign rd_blk = bus_addr[7:4];
  assign rd_idx = bus_addr[3:2];

  always_comb begin
    bus_rdata = '0;
    case (rd_blk)
      BLK_VEC:  bus_rdata = vec_q;
      BLK_BASE: bus_rdata = base_q;
      BLK_PEND, BLK_MASK, BLK_SEL: begin
        for (int k = 0; k < NUM_WORDS; k++) begin
          if (rd_idx == 2'(k)) begin
            if (rd_blk == BLK_PEND)      bus_rdata = pend_q[k*32 +: 32];
            else if (rd_blk == BLK_MASK) bus_rdata = mask_q[k*32 +: 32];
            else                         bus_rdata = sel_q[k*32 +: 32];
          end
        end
      end
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_WORDS = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_WORDS*32-1:0] pend_q,
  input logic [NUM_WORDS*32-1:0] mask_q,
  input logic [NUM_WORDS*32-1:0] sel_q,
  input logic [31:0]             vec_q,
  input logic [31:0]             base_q,
  input logic                    irq_o,
  input logic                    fiq_o
);
  localparam int NSRC  = NUM_WORDS * 32;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  live, live_sh, below;
  logic [IDX_W-1:0] vidx;
  assign live    = pend_q & ~mask_q;
  assign vidx    = vec_q[IDX_W+1:2];
  assign live_sh = live >> vidx;
  assign below   = (NSRC'(1) << vidx) - NSRC'(1);

  AST_IRQ_TRACKS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|live)); // R2
  AST_FIQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (|(live & sel_q))); // R3
  AST_FIQ_UNDER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o); // R3
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q[1:0] == 2'b00); // R4
  AST_VEC_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> live_sh[0]); // R5
  AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((live & below) == '0)); // R5
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_q == 32'h0)); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00); // R8
endmodule

bind irq_vector_ctrl vic_checker #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q), .sel_q(sel_q),
  .vec_q(vec_q), .base_q(base_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NW = 3;
  localparam int NS = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [7:0]    addr = '0;
  logic          wen = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [NS-1:0] m_mask = '0;
  logic [NS-1:0] m_sel  = '0;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.NUM_WORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // reference: explicit word-then-bit search, numbers times four
  function automatic logic [31:0] ref_vec(input logic [NS-1:0] act);
    logic [31:0] r;
    bit found;
    r = 0; found = 0;
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < 32; b++)
        if (!found && act[w*32+b]) begin
          found = 1; r = (w * 32 + b) * 4;
        end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    logic [NS-1:0] act;
    logic [31:0] v;
    act = src & ~m_mask;
    rd(8'h00, v);
    chk({req, " vector"}, v, ref_vec(act));
    chk({req, " irq"}, 32'(irq), 32'(|act));
    chk({req, " fiq"}, 32'(fiq), 32'(|(act & m_sel)));
  endtask

  task automatic set_mask(input int w, input logic [31:0] d);
    wr(8'h30 + 8'(4 * w), d);
    m_mask[w*32 +: 32] = d;
  endtask

  task automatic set_sel(input int w, input logic [31:0] d);
    wr(8'h40 + 8'(4 * w), d);
    m_sel[w*32 +: 32] = d;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(8'h10, d); chk("R10 base", d, 0);
    rd(8'h34, d); chk("R10 mask", d, 0);
    rd(8'h48, d); chk("R10 sel", d, 0);
    rd(8'h00, d); chk("R10 vector", d, 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 fiq", 32'(fiq), 0);

    // R4 R2 R3: sweep each single source
    for (int w = 0; w < NW; w++) set_sel(w, 32'h9249_2492 >> w);
    for (int s = 0; s < NS; s++) begin
      src = '0; src[s] = 1'b1;
      @(negedge clk);
      check_outputs("R4 single");
      rd(8'h20 + 8'(4 * (s / 32)), d);
      chk("R1 pending word", d, 32'h1 << (s % 32));
    end

    // R6 no source / all masked
    src = '0; @(negedge clk);
    check_outputs("R6 idle");
    src = {NS{1'b1}};
    for (int w = 0; w < NW; w++) set_mask(w, 32'hFFFF_FFFF);
    check_outputs("R6 all masked");
    rd(8'h00, d); chk("R6 vector zero", d, 0);

    // R5 lowest wins: unmask word 2 top bit and word 1 bit 7
    set_mask(2, 32'h7FFF_FFFF);
    check_outputs("R5 only high");
    set_mask(1, 32'hFFFF_FF7F);
    check_outputs("R5 word1 wins");
    rd(8'h00, d); chk("R5 vector", d, (32 + 7) * 4);

    // R7 vector writes ignored
    wr(8'h00, 32'hFFFF_FFFC);
    rd(8'h00, d); chk("R7 vector write", d, (32 + 7) * 4);

    // R1 pending writes ignored
    src = '0; src[40] = 1'b1; src[3] = 1'b1;
    @(negedge clk);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R1 pending write", d, 32'h8);
    rd(8'h24, d); chk("R1 pending word1", d, 32'h100);

    // R8 base alignment
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, d); chk("R8 base", d, 32'hDEAD_BEEC);

    // R9 out-of-range word index and unmapped offsets
    wr(8'h3C, 32'h0);
    rd(8'h3C, d); chk("R9 mask idx3", d, 0);
    rd(8'h38, d); chk("R9 mask word2 kept", d, 32'h7FFF_FFFF);
    rd(8'h2C, d); chk("R9 pend idx3", d, 0);
    rd(8'h50, d); chk("R9 unmapped", d, 0);
    rd(8'hF4, d); chk("R9 unmapped high", d, 0);

    // R11 mask write and source change in the same cycle
    for (int w = 0; w < NW; w++) set_mask(w, 32'hFFFF_FFFF);
    src = '0; src[70] = 1'b1;
    addr = 8'h38; wdata = ~(32'h1 << 6); wen = 1'b1;
    @(negedge clk);
    wen = 1'b0; m_mask[64 +: 32] = ~(32'h1 << 6);
    check_outputs("R11 same cycle");
    rd(8'h00, d); chk("R11 vector", d, 70 * 4);

    // R2 R3 R5 random patterns with register churn
    for (int it = 0; it < 300; it++) begin
      logic [NS-1:0] ns;
      for (int w = 0; w < NW; w++) begin
        rng = nxt(rng); ns[w*32 +: 32] = rng;
        rng = nxt(rng); ns[w*32 +: 32] &= rng;
        rng = nxt(rng); ns[w*32 +: 32] &= rng;
      end
      rng = nxt(rng);
      if (rng[0]) begin
        logic [31:0] m;
        m = nxt(rng) | nxt(nxt(rng));
        addr = 8'h30 + 8'(4 * (rng[5:4] % 3));
        wdata = m; wen = 1'b1;
        m_mask[(rng[5:4] % 3) * 32 +: 32] = m;
      end else if (rng[1]) begin
        logic [31:0] m;
        m = nxt(rng);
        addr = 8'h40 + 8'(4 * (rng[5:4] % 3));
        wdata = m; wen = 1'b1;
        m_sel[(rng[5:4] % 3) * 32 +: 32] = m;
      end
      src = ns;
      @(negedge clk);
      wen = 1'b0;
      check_outputs("R2 R3 R5 random");
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule